// File: doc/BRIEF.md
# Memory-Mapped SPI Master

This block is a single-device SPI master that a processor drives through five 32-bit registers on a simple synchronous read/write bus. Software controls the one chip-select line directly. It picks an 8-bit or 16-bit frame size and a serial clock divider. It then starts a frame by writing the outgoing word. The block shifts the word out most significant bit first in SPI mode 0. In that mode the clock idles low, output data changes on the falling edge and input data is sampled on the rising edge. The block captures the incoming word and raises a completion flag that software polls and later clears.

The serial clock is derived from the system clock. A 5-bit code selects the divider: bit 4 must be set, and the low four bits give the half period in system clocks. This allows even divisors from 4 to 30. A write to the transmit register while a frame is running is dropped, so software must wait for the flag before it starts the next word.

Top module: `spi_mmio_master`

## Requirements
- R1: After reset the chip-select output `spi_cs_n` is high and `spi_sck` is low. Every register reads 0.
- R2: Bit 0 of the control register (offset 0x00) sets the chip select: 1 drives `spi_cs_n` low and 0 drives it high. The bit reads back.
- R3: The configuration register (offset 0x04) reads back bits 5:0. When bit 4 is 1 and bits 3:0 hold a value h from 2 to 15, each SCK phase lasts h system clocks. A frame of n bits then lasts 2·h·n clocks, counted from the write that starts it to its last falling SCK edge.
- R4: A code with bit 4 clear, or with bits 3:0 below 2, behaves as h = 2 (divisor 4).
- R5: A write to the data-out register (offset 0x08) starts a frame. With configuration bit 5 at 0, the frame is 8 SCK pulses carrying bits 7:0 of the written word, most significant bit first. MOSI changes only after falling edges, and SCK is low whenever no frame runs.
- R6: With configuration bit 5 at 1, the frame is 16 SCK pulses carrying bits 15:0, most significant bit first.
- R7: MISO is sampled on each rising SCK edge. After the frame the data-in register (offset 0x0C) returns the received word, zero-extended from 8 bits in 8-bit mode.
- R8: Bit 0 of the cause register (offset 0x10) becomes 1 one system clock after the last falling SCK edge of a frame. Writing 0 clears it, and writing any nonzero value leaves it unchanged.
- R9: A data-out write while a frame is in progress is ignored. The running frame keeps its length and data, and the cause bit stays 0 until that frame ends.
- R10: Read data appears on `bus_rdata` one clock after `bus_rd`. Offsets outside the five registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after `bus_rd` |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench targets the divider codes at and outside the legal range: 0x00, 0x0F, 0x11 (each of which must fall back to divisor 4), 0x12 and 0x1F. A wrong clamp gives the wrong SCK high time and the wrong frame length. It runs both frame sizes against a slave model that returns a known word. A design that sampled on the wrong edge, or left stale high bits in 8-bit mode, would return a shifted or unmasked data-in value. It writes a second word in the middle of a frame, where a design that restarted would give more than the expected pulse count or altered MOSI bits. It also writes a nonzero value to the cause register, which a design that cleared on any write would answer with 0.

// File: rtl/spi_mmio_pkg.sv
package spi_mmio_pkg;
  localparam int BUS_W    = 32;
  localparam int FRAME_W  = 16;
  localparam int NARROW_W = 8;
  localparam int CODE_W   = 5;
  localparam int HALF_W   = 4;
  localparam int HALF_MIN = 2;

  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_CFG   = 'h04;
  localparam int OFF_TX    = 'h08;
  localparam int OFF_RX    = 'h0C;
  localparam int OFF_CAUSE = 'h10;

  typedef struct packed {
    logic              wide;
    logic [CODE_W-1:0] code;
  } spi_cfg_t;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_mmio_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int HW = HALF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] code,
  output logic          tick
);
  localparam logic [HW-1:0] HMIN = HW'(HALF_MIN);

  logic [HW-1:0] half_cyc;
  logic [HW-1:0] cnt;

  // Legal codes have the top bit set and a half period of at least HMIN.
  always_comb begin
    if (code[CW-1] && (code[HW-1:0] >= HMIN)) half_cyc = code[HW-1:0];
    else                                      half_cyc = HMIN;
  end

  assign tick = run && (cnt == half_cyc - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assert_half_clamped_R4: assert property (@(posedge clk) disable iff (rst)
    half_cyc >= HMIN);
  assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt < half_cyc);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_mmio_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int NW = NARROW_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wide,
  input  logic [FW-1:0] tx_word,
  input  logic          tick,
  input  logic          miso,
  output logic          busy,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [FW-1:0] rx_word
);
  localparam int BW = $clog2(FW);
  localparam logic [BW-1:0] LAST_W = BW'(FW - 1);
  localparam logic [BW-1:0] LAST_N = BW'(NW - 1);

  logic [FW-1:0] tx_sr;
  logic [FW-1:0] rx_sr;
  logic [BW-1:0] bits_left;
  logic          wide_q;

  assign mosi    = tx_sr[FW-1];
  assign rx_word = wide_q ? rx_sr : {{(FW-NW){1'b0}}, rx_sr[NW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; sck <= 1'b0; done <= 1'b0; wide_q <= 1'b0;
      tx_sr <= '0; rx_sr <= '0; bits_left <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          sck       <= 1'b0;
          wide_q    <= wide;
          rx_sr     <= '0;
          bits_left <= wide ? LAST_W : LAST_N;
          tx_sr     <= wide ? tx_word : {tx_word[NW-1:0], {(FW-NW){1'b0}}};
        end
      end else if (tick) begin
        if (!sck) begin
          sck   <= 1'b1;
          rx_sr <= {rx_sr[FW-2:0], miso};
        end else begin
          sck <= 1'b0;
          if (bits_left == '0) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bits_left <= bits_left - 1'b1;
            tx_sr     <= {tx_sr[FW-2:0], 1'b0};
          end
        end
      end
    end
  end

  assert_sck_idle_low_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> bits_left <= $past(bits_left));
  assert_mosi_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$fell(sck)) |-> $stable(mosi));
  assert_done_after_fall_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!sck && $past(sck)));
endmodule

// File: rtl/spi_mmio_master.sv
module spi_mmio_master
  import spi_mmio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_TX    = ADDR_W'(OFF_TX);
  localparam logic [ADDR_W-1:0] A_RX    = ADDR_W'(OFF_RX);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFF_CAUSE);
  localparam int CFG_W = $bits(spi_cfg_t);

  logic               cs_on;
  spi_cfg_t           cfg_q;
  logic [FRAME_W-1:0] tx_q;
  logic [FRAME_W-1:0] rx_q;
  logic               flag_q;

  logic               busy, done, tick;
  logic [FRAME_W-1:0] rx_word;
  logic               wr_tx, wr_cause;

  assign wr_tx    = bus_wr && (bus_addr == A_TX);
  assign wr_cause = bus_wr && (bus_addr == A_CAUSE);
  assign spi_cs_n = ~cs_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_on <= 1'b0; cfg_q <= '0; tx_q <= '0; rx_q <= '0; flag_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) cs_on <= bus_wdata[0];
      if (bus_wr && bus_addr == A_CFG)  cfg_q <= spi_cfg_t'(bus_wdata[CFG_W-1:0]);
      if (wr_tx && !busy)               tx_q  <= bus_wdata[FRAME_W-1:0];
      if (done)                         rx_q  <= rx_word;
      if (done)                                flag_q <= 1'b1;
      else if (wr_cause && bus_wdata == '0)    flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= BUS_W'(cs_on);
        A_CFG:   bus_rdata <= BUS_W'(cfg_q);
        A_TX:    bus_rdata <= BUS_W'(tx_q);
        A_RX:    bus_rdata <= BUS_W'(rx_q);
        A_CAUSE: bus_rdata <= BUS_W'(flag_q);
        default: bus_rdata <= '0;
      endcase
    end
  end

  spi_clk_div i_div (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .code (cfg_q.code),
    .tick (tick)
  );

  spi_shifter i_shift (
    .clk     (clk),
    .rst     (rst),
    .start   (wr_tx),
    .wide    (cfg_q.wide),
    .tx_word (bus_wdata[FRAME_W-1:0]),
    .tick    (tick),
    .miso    (spi_miso),
    .busy    (busy),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .done    (done),
    .rx_word (rx_word)
  );

  assert_cs_off_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> spi_cs_n);
  assert_cause_nonzero_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_cause && bus_wdata != '0 && !done) |=> $stable(flag_q));
  assert_flag_follows_done_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> flag_q);
endmodule

// File: tb/test_spi_mmio_master.sv
module test_spi_mmio_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  int n_chk = 0, n_bad = 0;
  localparam int TCLK = 20;

  spi_mmio_master i_spi_mmio_master (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  always #(TCLK/2) clk = ~clk;

  // Slave model and edge monitors
  logic [15:0] sl_word = '0;
  int          sl_idx = 0;
  int          rise_cnt = 0;
  logic [15:0] mosi_cap = '0;
  time         t_rise = 0, t_fall = 0, t_wr = 0;
  int          hi_len = 0;

  always @(posedge spi_sck) begin
    t_rise   = $time;
    rise_cnt = rise_cnt + 1;
    mosi_cap = {mosi_cap[14:0], spi_mosi};
  end
  always @(negedge spi_sck) begin
    t_fall = $time;
    hi_len = int'((t_fall - t_rise) / TCLK);
    if (sl_idx > 0) begin
      sl_idx   = sl_idx - 1;
      spi_miso = sl_word[sl_idx];
    end
  end

  function automatic int exp_half(input logic [4:0] code);
    return (code[4] && code[3:0] >= 2) ? int'(code[3:0]) : 2;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); t_wr = $time;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic run_frame(input logic [15:0] data, input logic wide,
                           input logic [4:0] code, input logic [15:0] sw,
                           input logic intrude, input string tag);
    logic [31:0] rd;
    int n, h;
    time t_start;
    n = wide ? 16 : 8;
    h = exp_half(code);
    bus_write(5'h04, {26'b0, wide, code});
    bus_write(5'h10, 32'h0);
    sl_word = sw; sl_idx = n - 1; spi_miso = sw[n-1];
    rise_cnt = 0; mosi_cap = '0;
    bus_write(5'h08, {16'hA5A5, data});
    t_start = t_wr;
    if (intrude) begin
      bus_write(5'h08, {16'h0, ~data});
      bus_read(5'h10, rd);
      check({tag, " R9 cause low mid-frame"}, rd, 32'h0);
    end
    rd = '0;
    for (int k = 0; k < 3000 && rd[0] !== 1'b1; k++) bus_read(5'h10, rd);
    check({tag, " R8 cause set"}, rd, 32'h1);
    check({tag, " R5/R6 pulse count"}, rise_cnt, n);
    check({tag, " R5/R6 mosi bits"}, {16'h0, mosi_cap},
          wide ? {16'h0, data} : {24'h0, data[7:0]});
    check({tag, " R3/R4 sck high length"}, hi_len, h);
    check({tag, " R3/R4 frame length"}, int'((t_fall - t_start) / TCLK), 2 * h * n);
    bus_read(5'h0C, rd);
    check({tag, " R7 data-in"}, rd, wide ? {16'h0, sw} : {24'h0, sw[7:0]});
    check({tag, " R5 sck idle low"}, spi_sck, 1'b0);
  endtask

  initial begin
    repeat (5000 * 30) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    check("R1 cs_n after reset", spi_cs_n, 1'b1);
    check("R1 sck after reset", spi_sck, 1'b0);
    for (int a = 0; a <= 16; a += 4) begin
      bus_read(5'(a), rd);
      check("R1 register reset value", rd, 32'h0);
    end

    bus_write(5'h00, 32'h1);
    check("R2 cs_n asserted", spi_cs_n, 1'b0);
    bus_read(5'h00, rd);
    check("R2 control readback", rd, 32'h1);
    bus_write(5'h04, 32'hFFFF_FFF3);
    bus_read(5'h04, rd);
    check("R3 config readback", rd, 32'h33);
    bus_read(5'h14, rd);
    check("R10 unmapped offset", rd, 32'h0);

    // Directed divider corners
    run_frame(16'h00A5, 1'b0, 5'h00, 16'h003C, 1'b0, "clamp00");
    run_frame(16'h005A, 1'b0, 5'h0F, 16'h00C3, 1'b0, "clamp0F");
    run_frame(16'h0081, 1'b0, 5'h11, 16'h0001, 1'b0, "clamp11");
    run_frame(16'h1234, 1'b1, 5'h12, 16'hBEEF, 1'b0, "min12");
    run_frame(16'h8001, 1'b1, 5'h1F, 16'h7FFE, 1'b0, "max1F");

    // Busy write ignored
    run_frame(16'h00C6, 1'b0, 5'h13, 16'h0055, 1'b1, "intrude");

    // Nonzero cause write ignored, zero clears
    bus_write(5'h10, 32'h5);
    bus_read(5'h10, rd);
    check("R8 nonzero write keeps cause", rd, 32'h1);
    bus_write(5'h10, 32'h0);
    bus_read(5'h10, rd);
    check("R8 zero write clears cause", rd, 32'h0);

    // Random frames
    for (int i = 0; i < 20; i++) begin
      logic [31:0] r;
      r = $urandom();
      run_frame(r[15:0], r[16], r[21:17], 16'($urandom()), 1'b0, "random");
    end

    bus_write(5'h00, 32'h0);
    check("R2 cs_n released", spi_cs_n, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule